// File: doc/BRIEF.md
# DShot Frame Transmitter

This block drives digital throttle frames to up to four motor controllers that share one timing group. A command strobe captures one throttle value and one telemetry-request flag for each lane. At the next free slot the block builds a 16-bit frame per lane: an 11-bit value, a request bit, and a 4-bit checksum. It sends all lanes in parallel, most significant bit first, as fixed-period duty-cycle bits.

Each frame starts with a few all-low lead-in slots. After the last data slot every line stays low for a programmable gap. A command that arrives while a frame or gap is in progress waits until the gap is over. Once the first command has been taken, the last values are resent automatically whenever the output has been idle for a set number of cycles. Per-lane options cover reversible (3D) throttle mapping and a safety override. The override replaces the command with a stored safe value unless the lane is exempt.

Top module: `dshot_tx`

## Requirements
- R1: Each lane frame is `{V[10:0], T, C[3:0]}`. V is the mapped value and T is the telemetry-request bit. C is the low nibble of W ^ (W>>4) ^ (W>>8), where W = {V, T}.
- R2: A bit slot lasts 20 ticks. A 0 bit is high for the first 7 ticks and a 1 bit is high for the first 14 ticks. Bits go out from frame bit 15 down to bit 0. PRE_SLOTS all-low slots come first.
- R3: One tick lasts BASE_DIV << (3 - rate_sel) clock cycles. rate_sel 3, 2, 1 and 0 give 1200, 600, 300 and 150 kbit/s when BASE_DIV makes one tick 1/24 µs. rate_sel is latched when a frame starts.
- R4: A command of 0 gives V = 0. A command above 2000 is treated as 2000. Any other nonzero command c gives V = c + 47.
- R5: When a lane's mode3d bit is set, the command c (after clamping) is remapped before the R4 rule. If c < 1000 it becomes 2000 - c. If c > 1000 it becomes c - 1000. If c = 1000 it becomes 0.
- R6: When safety_on is high and the lane's safety_exempt bit is 0, that lane's safe_value replaces its command before mapping. Exempt lanes use their command.
- R7: A telemetry_req bit captured with a command is sent in the next frame that starts. It is then cleared, so later frames carry T = 0 until a new request arrives.
- R8: busy_o rises one cycle after the clock edge that samples cmd_valid, when the block is idle. Every pulse rises on all lanes in the same cycle.
- R9: busy_o stays high for exactly (PRE_SLOTS+16)·20 ticks plus gap_len+1 cycles. All lines are low during the gap.
- R10: A command that arrives while busy_o is high is held, and the latest one wins. It starts one cycle after busy_o falls, so busy_o is low for exactly one cycle.
- R11: After the first command, if busy_o stays low for REFRESH_CYCLES cycles, the last values are resent. No frame is ever sent before the first command.
- R12: After reset all lines and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Strobe that captures throttle and telemetry_req |
| throttle | input | LANES*11 | Command per lane, lane i at bits [11i+10:11i] |
| telemetry_req | input | LANES | Telemetry-request flag per lane |
| mode3d | input | LANES | Reversible throttle mapping enable per lane |
| safety_on | input | 1 | Safety override active |
| safety_exempt | input | LANES | Lanes that ignore the safety override |
| safe_value | input | LANES*11 | Override command per lane |
| rate_sel | input | 2 | Bitrate select (see R3) |
| gap_len | input | GAP_W | Post-frame gap length in cycles, minus one |
| dshot_o | output | LANES | Serial line per lane |
| busy_o | output | 1 | Frame or gap in progress |

## Verification
busy_o is due one cycle after the edge that takes a command. The bench samples it on the falling edge before and after that rise. Frame length and gap length are measured by counting falling-edge samples while busy_o is high, and idle time by counting them while it is low. These counts are compared with the closed-form values from R9, R10 and R11. A monitor decodes every pulse by its high time in cycles. It pops the expected four-lane frame from a queue when sixteen bits have arrived on every lane. It also checks at each rising edge that the lanes rise together.

// File: rtl/dshot_pkg.sv
package dshot_pkg;
   localparam int VAL_W      = 11;
   localparam int FRAME_W    = 16;
   localparam int TICK_W     = 5;
   localparam int SLOT_TICKS = 20;
   localparam int ZERO_HIGH  = 7;
   localparam int ONE_HIGH   = 14;
   localparam int CMD_MAX    = 2000;
   localparam int CMD_MID    = 1000;
   localparam int VAL_OFS    = 47;

   typedef enum logic [1:0] {SEQ_IDLE, SEQ_SEND, SEQ_GAP} seq_state_e;

   // clamp, optional reversible remap, then offset of nonzero values
   function automatic logic [VAL_W-1:0] map_cmd(input logic [VAL_W-1:0] raw, input logic rev);
      logic [VAL_W-1:0] c;
      logic [VAL_W-1:0] m;
      c = (raw > VAL_W'(CMD_MAX)) ? VAL_W'(CMD_MAX) : raw;
      if (!rev)                    m = c;
      else if (c < VAL_W'(CMD_MID)) m = VAL_W'(CMD_MAX) - c;
      else if (c > VAL_W'(CMD_MID)) m = c - VAL_W'(CMD_MID);
      else                         m = '0;
      return (m == '0) ? '0 : m + VAL_W'(VAL_OFS);
   endfunction

   function automatic logic [FRAME_W-1:0] pack_frame(input logic [VAL_W-1:0] v, input logic tlm);
      logic [11:0] w;
      w = {v, tlm};
      return {w, w[3:0] ^ w[7:4] ^ w[11:8]};
   endfunction
endpackage

// File: rtl/dshot_rate_div.sv
module dshot_rate_div #(
   parameter int BASE_DIV = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] rate,
   output logic       tick_en
);
   localparam int CNT_W = $clog2(BASE_DIV * 8) + 1;

   generate
      if (BASE_DIV < 1) begin : g_bad_div
         $error("BASE_DIV must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim     = CNT_W'(BASE_DIV) << (2'd3 - rate);
   assign tick_en = run && (cnt == lim - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || tick_en)  cnt <= '0;
      else                       cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/dshot_seq.sv
module dshot_seq
   import dshot_pkg::*;
#(
   parameter int PRE_SLOTS      = 2,
   parameter int GAP_W          = 8,
   parameter int REFRESH_CYCLES = 20000,
   parameter int BASE_DIV       = 1,
   localparam int LAST_SLOT     = PRE_SLOTS + FRAME_W - 1,
   localparam int SLOT_W        = $clog2(LAST_SLOT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              armed,
   input  logic [1:0]        rate_sel,
   input  logic [GAP_W-1:0]  gap_len,
   output logic              start_o,
   output logic              busy_o,
   output logic              sending_o,
   output logic              in_gap_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic [TICK_W-1:0] tick_o
);
   localparam int IDLE_W = $clog2(REFRESH_CYCLES + 1);

   seq_state_e        state;
   logic [1:0]        rate_q;
   logic [SLOT_W-1:0] slot;
   logic [TICK_W-1:0] tick;
   logic [GAP_W-1:0]  gap_cnt;
   logic [IDLE_W-1:0] idle_cnt;
   logic              tick_en;
   logic              refresh_due;

   assign refresh_due = armed && (idle_cnt == IDLE_W'(REFRESH_CYCLES - 1));
   assign start_o     = (state == SEQ_IDLE) && (req || refresh_due);
   assign busy_o      = (state != SEQ_IDLE);
   assign sending_o   = (state == SEQ_SEND);
   assign in_gap_o    = (state == SEQ_GAP);
   assign slot_o      = slot;
   assign tick_o      = tick;

   dshot_rate_div #(.BASE_DIV(BASE_DIV)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (sending_o),
      .rate    (rate_q),
      .tick_en (tick_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         rate_q   <= '0;
         slot     <= '0;
         tick     <= '0;
         gap_cnt  <= '0;
         idle_cnt <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start_o) begin
                  state    <= SEQ_SEND;
                  slot     <= '0;
                  tick     <= '0;
                  rate_q   <= rate_sel;
                  idle_cnt <= '0;
               end else if (armed) begin
                  idle_cnt <= idle_cnt + IDLE_W'(1);
               end
            end
            SEQ_SEND: begin
               if (tick_en) begin
                  if (tick == TICK_W'(SLOT_TICKS - 1)) begin
                     tick <= '0;
                     if (slot == SLOT_W'(LAST_SLOT)) begin
                        state   <= SEQ_GAP;
                        gap_cnt <= '0;
                     end else begin
                        slot <= slot + SLOT_W'(1);
                     end
                  end else begin
                     tick <= tick + TICK_W'(1);
                  end
               end
            end
            SEQ_GAP: begin
               if (gap_cnt >= gap_len) state   <= SEQ_IDLE;
               else                    gap_cnt <= gap_cnt + GAP_W'(1);
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // slot and tick counters stay inside the frame layout
   assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sending_o |-> (slot <= SLOT_W'(LAST_SLOT)) && (tick < TICK_W'(SLOT_TICKS)));

   // a frame only begins after a command has been seen
   assert_refresh_needs_arm_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(req) || $past(armed)));
endmodule

// File: rtl/dshot_lane.sv
module dshot_lane
   import dshot_pkg::*;
#(
   parameter int PRE_SLOTS = 2,
   parameter int SLOT_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               sending,
   input  logic [SLOT_W-1:0]  slot,
   input  logic [TICK_W-1:0]  tick,
   output logic               line_o
);
   localparam int LAST_SLOT = PRE_SLOTS + FRAME_W - 1;

   logic [FRAME_W-1:0] frame_q;
   logic               in_data;
   logic [3:0]         pos;
   logic               bit_v;
   logic [TICK_W-1:0]  high_lim;
   logic               line_q;

   generate
      if (PRE_SLOTS == 0) begin : g_no_lead
         assign in_data = 1'b1;
      end else begin : g_lead
         assign in_data = (slot >= SLOT_W'(PRE_SLOTS));
      end
   endgenerate

   assign pos      = 4'(SLOT_W'(LAST_SLOT) - slot);
   assign bit_v    = frame_q[pos];
   assign high_lim = bit_v ? TICK_W'(ONE_HIGH) : TICK_W'(ZERO_HIGH);
   assign line_o   = line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         line_q  <= 1'b0;
      end else begin
         if (load) frame_q <= frame_in;
         line_q <= sending && in_data && (tick < high_lim);
      end
   end

   // every pulse begins at the first tick of its slot
   assert_rise_at_slot_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_o) |-> ($past(tick) == '0));
endmodule

// File: rtl/dshot_tx.sv
module dshot_tx
   import dshot_pkg::*;
#(
   parameter int LANES          = 4,
   parameter int PRE_SLOTS      = 2,
   parameter int GAP_W          = 8,
   parameter int REFRESH_CYCLES = 20000,
   parameter int BASE_DIV       = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [LANES*VAL_W-1:0] throttle,
   input  logic [LANES-1:0]       telemetry_req,
   input  logic [LANES-1:0]       mode3d,
   input  logic                   safety_on,
   input  logic [LANES-1:0]       safety_exempt,
   input  logic [LANES*VAL_W-1:0] safe_value,
   input  logic [1:0]             rate_sel,
   input  logic [GAP_W-1:0]       gap_len,
   output logic [LANES-1:0]       dshot_o,
   output logic                   busy_o
);
   localparam int LAST_SLOT = PRE_SLOTS + FRAME_W - 1;
   localparam int SLOT_W    = $clog2(LAST_SLOT + 1);

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (REFRESH_CYCLES < 2) begin : g_bad_refresh
         $error("REFRESH_CYCLES must be at least 2");
      end
   endgenerate

   logic [VAL_W-1:0]  thr_q [LANES];
   logic [LANES-1:0]  telem_q;
   logic              pend;
   logic              armed;
   logic              start;
   logic              sending;
   logic              in_gap;
   logic [SLOT_W-1:0] slot;
   logic [TICK_W-1:0] tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LANES; i++) thr_q[i] <= '0;
         telem_q <= '0;
         pend    <= 1'b0;
         armed   <= 1'b0;
      end else begin
         if (cmd_valid) begin
            for (int i = 0; i < LANES; i++) thr_q[i] <= throttle[i*VAL_W +: VAL_W];
         end
         if (cmd_valid)  pend <= 1'b1;
         else if (start) pend <= 1'b0;
         telem_q <= (start ? '0 : telem_q) | (cmd_valid ? telemetry_req : '0);
         armed   <= armed | cmd_valid;
      end
   end

   dshot_seq #(
      .PRE_SLOTS      (PRE_SLOTS),
      .GAP_W          (GAP_W),
      .REFRESH_CYCLES (REFRESH_CYCLES),
      .BASE_DIV       (BASE_DIV)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (pend),
      .armed     (armed),
      .rate_sel  (rate_sel),
      .gap_len   (gap_len),
      .start_o   (start),
      .busy_o    (busy_o),
      .sending_o (sending),
      .in_gap_o  (in_gap),
      .slot_o    (slot),
      .tick_o    (tick)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [VAL_W-1:0]   raw;
         logic [VAL_W-1:0]   val;
         logic [FRAME_W-1:0] frame;

         assign raw   = (safety_on && !safety_exempt[g]) ? safe_value[g*VAL_W +: VAL_W] : thr_q[g];
         assign val   = map_cmd(raw, mode3d[g]);
         assign frame = pack_frame(val, telem_q[g]);

         dshot_lane #(.PRE_SLOTS(PRE_SLOTS), .SLOT_W(SLOT_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .frame_in (frame),
            .sending  (sending),
            .slot     (slot),
            .tick     (tick),
            .line_o   (dshot_o[g])
         );

         // the four nibbles of a well-formed frame XOR to zero
         assert_frame_checksum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> ((frame[15:12] ^ frame[11:8] ^ frame[7:4] ^ frame[3:0]) == 4'h0));
      end
   endgenerate

   // held command is taken as soon as the block is free
   assert_pending_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !busy_o) |=> busy_o);

   // lines stay low for the whole gap
   assert_gap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_gap |-> (dshot_o == '0));

   // no pulse outside a busy window
   assert_line_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dshot_o != '0) |-> busy_o);

   // all lanes rise together
   assert_lanes_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((dshot_o != '0) && ($past(dshot_o) == '0)) |-> (&dshot_o));
endmodule

// File: tb/dshot_tx_tb.sv
module dshot_tx_tb;
   localparam int LANES   = 4;
   localparam int PRE     = 2;
   localparam int REFRESH = 1500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [43:0] throttle = '0;
   logic [3:0]  telemetry_req = '0;
   logic [3:0]  mode3d = '0;
   logic        safety_on = 1'b0;
   logic [3:0]  safety_exempt = '0;
   logic [43:0] safe_value = '0;
   logic [1:0]  rate_sel = 2'd3;
   logic [7:0]  gap_len = 8'd30;
   logic [3:0]  dshot_o;
   logic        busy_o;

   int checks = 0;
   int fails = 0;
   int cur_div = 1;

   logic [63:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   dshot_tx #(
      .LANES(LANES), .PRE_SLOTS(PRE), .GAP_W(8), .REFRESH_CYCLES(REFRESH), .BASE_DIV(1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .throttle(throttle),
      .telemetry_req(telemetry_req), .mode3d(mode3d), .safety_on(safety_on),
      .safety_exempt(safety_exempt), .safe_value(safe_value), .rate_sel(rate_sel),
      .gap_len(gap_len), .dshot_o(dshot_o), .busy_o(busy_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_frame(input int raw, input bit rev, input bit tlm);
      int c, v, w, cs;
      c = (raw > 2000) ? 2000 : raw;
      if (rev) c = (c < 1000) ? 2000 - c : (c > 1000) ? c - 1000 : 0;
      v  = (c == 0) ? 0 : c + 47;
      w  = v * 2 + (tlm ? 1 : 0);
      cs = (w ^ (w >> 4) ^ (w >> 8)) & 15;
      return 16'(w * 16 + cs);
   endfunction

   task automatic push4(input logic [15:0] f0, f1, f2, f3, input string tag);
      exp_q.push_back({f3, f2, f1, f0});
      tag_q.push_back(tag);
   endtask

   task automatic send(input int t0, t1, t2, t3, input logic [3:0] tl, input bit chk);
      @(negedge clk);
      throttle      = {11'(t3), 11'(t2), 11'(t1), 11'(t0)};
      telemetry_req = tl;
      cmd_valid     = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (chk) check(busy_o == 1'b0, "R8 busy before start", busy_o, 0);
      @(negedge clk);
      if (chk) check(busy_o == 1'b1, "R8 busy one cycle after command edge", busy_o, 1);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy_o) begin n++; @(negedge clk); end
   endtask

   task automatic count_idle(output int n);
      n = 0;
      while (!busy_o) begin n++; @(negedge clk); end
   endtask

   // monitor: decode pulses per lane and compare with the scoreboard
   logic [3:0]  prev;
   int          hcnt [4];
   int          nb [4];
   logic [15:0] sh [4];

   always @(negedge clk) begin
      if (!rst_n) begin
         prev = '0;
         for (int l = 0; l < 4; l++) begin hcnt[l] = 0; nb[l] = 0; sh[l] = '0; end
      end else begin
         if (prev == '0 && dshot_o != '0)
            check(dshot_o == 4'hF, "R8 lanes rise together", dshot_o, 15);
         for (int l = 0; l < 4; l++) begin
            if (dshot_o[l]) begin
               if (!prev[l]) hcnt[l] = 0;
               hcnt[l]++;
            end else if (prev[l]) begin
               check(hcnt[l] == 7 * cur_div || hcnt[l] == 14 * cur_div,
                     "R2/R3 pulse width", hcnt[l], 7 * cur_div);
               sh[l] = {sh[l][14:0], (hcnt[l] == 14 * cur_div)};
               nb[l]++;
            end
         end
         prev = dshot_o;
         if (nb[0] == 16 && nb[1] == 16 && nb[2] == 16 && nb[3] == 16) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1 unexpected frame", sh[0], 0);
            end else begin
               logic [63:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               for (int l = 0; l < 4; l++)
                  check(sh[l] == e[l*16 +: 16], t, sh[l], e[l*16 +: 16]);
            end
            for (int l = 0; l < 4; l++) nb[l] = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n;
      int bad;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 1'b0, "R12 busy after reset", busy_o, 0);
      check(dshot_o == '0, "R12 lines after reset", dshot_o, 0);

      // R11: no frame before the first command
      bad = 0;
      repeat (REFRESH + 100) begin @(negedge clk); if (busy_o || dshot_o != '0) bad++; end
      check(bad == 0, "R11 silent before first command", bad, 0);

      // frame A: value mapping, clamp, telemetry flag (R1 R4 R7), length (R9)
      cur_div = 1; rate_sel = 2'd3; gap_len = 8'd30;
      push4(exp_frame(0, 0, 0), exp_frame(1, 0, 1), exp_frame(1000, 0, 0), exp_frame(2047, 0, 0),
            "R1/R4 frame A");
      send(0, 1, 1000, 2047, 4'b0010, 1'b1);
      count_busy(n);
      check(n == 360 + 31, "R9 busy length at 1200k", n, 391);

      // frames B and C: C arrives during B and is held (R10), telemetry cleared (R7)
      push4(exp_frame(100, 0, 0), exp_frame(100, 0, 0), exp_frame(100, 0, 0), exp_frame(100, 0, 0),
            "R7 frame B telemetry cleared");
      push4(exp_frame(200, 0, 1), exp_frame(200, 0, 0), exp_frame(200, 0, 0), exp_frame(200, 0, 0),
            "R10 frame C held command");
      send(100, 100, 100, 100, 4'b0000, 1'b1);
      repeat (20) @(negedge clk);
      send(150, 150, 150, 150, 4'b0000, 1'b0);
      send(200, 200, 200, 200, 4'b0001, 1'b0);
      while (busy_o) @(negedge clk);
      count_idle(n);
      check(n == 1, "R10 held command starts after one idle cycle", n, 1);
      while (busy_o) @(negedge clk);

      // frame D: reversible mapping at 600k (R5 R3)
      cur_div = 2; rate_sel = 2'd2; gap_len = 8'd5; mode3d = 4'hF;
      push4(exp_frame(999, 1, 0), exp_frame(1000, 1, 0), exp_frame(1001, 1, 0), exp_frame(0, 1, 0),
            "R5 frame D reversible");
      send(999, 1000, 1001, 0, 4'b0000, 1'b1);
      count_busy(n);
      check(n == 720 + 6, "R3 busy length at 600k", n, 726);

      // frame E: safety override at 300k (R6), then refresh (R11)
      cur_div = 4; rate_sel = 2'd1; mode3d = 4'h0;
      safety_on = 1'b1; safety_exempt = 4'b0010;
      safe_value = {11'd0, 11'd300, 11'd0, 11'd0};
      push4(exp_frame(0, 0, 0), exp_frame(500, 0, 0), exp_frame(300, 0, 0), exp_frame(0, 0, 0),
            "R6 frame E safety override");
      push4(exp_frame(0, 0, 0), exp_frame(500, 0, 0), exp_frame(300, 0, 0), exp_frame(0, 0, 0),
            "R11 refresh frame");
      send(500, 500, 500, 500, 4'b0000, 1'b1);
      count_busy(n);
      check(n == 1440 + 6, "R3 busy length at 300k", n, 1446);
      count_idle(n);
      check(n == REFRESH, "R11 idle cycles before refresh", n, REFRESH);
      count_busy(n);
      check(n == 1440 + 6, "R11 refresh frame length", n, 1446);

      // frame F: 150k, all telemetry requests (R3 R7)
      cur_div = 8; rate_sel = 2'd0; safety_on = 1'b0;
      push4(exp_frame(2000, 0, 1), exp_frame(1500, 0, 1), exp_frame(48, 0, 1), exp_frame(5, 0, 1),
            "R7 frame F telemetry all lanes");
      send(2000, 1500, 48, 5, 4'b1111, 1'b1);
      count_busy(n);
      check(n == 2880 + 6, "R3 busy length at 150k", n, 2886);
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R1 all expected frames seen", exp_q.size(), 0);
      check(dshot_o == '0, "R9 lines idle low", dshot_o, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule